// File: doc/BRIEF.md
# Shared-Datapath GF(2^m) Multiplier and Divider

This block computes either the product a·b mod g or the quotient a/b mod g of two elements of a binary extension field held in polynomial basis. Both operations run on one iterative datapath built around the binary extended-GCD (Stein style) division step. In multiply mode the operands and the field polynomial are fed in bit-reversed. The same right-shifting iteration then accumulates the product, so no separate left-shifting multiplier exists.

A caller drives the operands, the field polynomial `g` (degree M, with both end coefficients set) and `mode`, then pulses `start` while the unit is idle. The first iteration is computed straight from the input pins. Every later iteration uses the registered state. When the last iteration completes, `done` pulses for one cycle. `result` then holds the answer until the next accepted start. This suits affine-coordinate elliptic-curve point arithmetic, where divisions and multiplications alternate and never overlap.

Top module: `gf_muldiv`

## Requirements
- R1: After reset `busy` and `done` are 0 and `result` is all zeros.
- R2: With `mode` = 1 (multiply), `result` equals a·b reduced modulo g, for any a and b, including zero operands.
- R3: With `mode` = 0 (divide) and b nonzero, `result` equals the element q with q·b = a modulo g.
- R4: A multiply takes M clock cycles. `done` is high in the cycle after the M-th rising edge, counting the edge that accepts `start` as the first.
- R5: A divide takes 2M-1 clock cycles, counted the same way as in R4.
- R6: `busy` is high from the edge that accepts `start` until `done` rises. `done` is a single-cycle pulse.
- R7: A `start` pulse while `busy` is high is ignored: result and latency of the running operation are unchanged.
- R8: `mode`, `a`, `b` and `g` are sampled only on the accepting edge. Changing them during an operation does not affect it.
- R9: After `done`, `result` stays constant until the next accepted `start`.
- R10: For M = 4, g = 10011, a = 1101, b = 0111, the multiply result is 0101 and the divide result is 1000.
- R11: During a multiply the signed step counter never goes negative and the exchange of working registers never happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| mode | input | 1 | 1 = multiply, 0 = divide; sampled with start |
| a | input | M | Multiplicand or dividend |
| b | input | M | Multiplier or divisor (nonzero for divide) |
| g | input | M+1 | Field polynomial, bit i is the coefficient of x^i |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | M | Product or quotient |

## Verification
The bench builds two copies of the block. One uses M = 8, where every divisor and quotient can be found by exhaustive search in the bench. It is driven with two different degree-8 field polynomials, to show that `g` really is an input and not a constant. The other uses M = 4, which reaches the small worked case of R10 and a latency of only 4 and 7 cycles. Random operands are mixed with zero, one, all-ones and a = b cases. Inputs are scrambled and extra `start` pulses are injected while the unit is busy.

// File: rtl/gf_muldiv_pkg.sv
package gf_muldiv_pkg;

   typedef enum logic {
      OP_DIV = 1'b0,
      OP_MUL = 1'b1
   } gf_op_e;

endpackage

// File: rtl/gf_operand_mux.sv
// Builds the initial working state for either operation from the pins.
module gf_operand_mux
   import gf_muldiv_pkg::*;
#(
   parameter int M  = 8,
   parameter int DW = 5
) (
   input  gf_op_e         op,
   input  logic [M-1:0]   a,
   input  logic [M-1:0]   b,
   input  logic [M:0]     g,
   output logic [M-1:0]   r_init,
   output logic [M:0]     s_init,
   output logic [M-1:0]   u_init,
   output logic [M:0]     v_init,
   output logic [M:0]     p_init,
   output logic [DW-1:0]  d_init
);

   logic [M-1:0] a_rev;
   logic [M-1:0] b_rev;
   logic [M:0]   g_rev;

   // reciprocal forms: reverse coefficient order
   for (genvar i = 0; i < M; i++) begin : g_rev_ab
      assign a_rev[i] = a[M-1-i];
      assign b_rev[i] = b[M-1-i];
   end
   for (genvar i = 0; i <= M; i++) begin : g_rev_g
      assign g_rev[i] = g[M-i];
   end

   always_comb begin
      if (op == OP_MUL) begin
         r_init = b_rev;
         s_init = '0;
         u_init = '0;
         v_init = {a_rev, 1'b0};
         p_init = g_rev;
         d_init = DW'(M);
      end else begin
         r_init = b;
         s_init = g;
         u_init = a;
         v_init = '0;
         p_init = g;
         d_init = '1;            // minus one
      end
   end

endmodule

// File: rtl/gf_stein_step.sv
// One combinational iteration of the shared right-shifting update.
module gf_stein_step #(
   parameter int M  = 8,
   parameter int DW = 5
) (
   input  logic [M-1:0]  r_cur,
   input  logic [M:0]    s_cur,
   input  logic [M-1:0]  u_cur,
   input  logic [M:0]    v_cur,
   input  logic [M:0]    p_cur,
   input  logic [DW-1:0] d_cur,
   output logic [M-1:0]  r_nxt,
   output logic [M:0]    s_nxt,
   output logic [M-1:0]  u_nxt,
   output logic [M:0]    v_nxt,
   output logic [DW-1:0] d_nxt,
   output logic          swap
);

   logic add_en;
   logic red_en;

   assign add_en = r_cur[0];
   assign red_en = u_cur[0] ^ (add_en & v_cur[0]);
   assign swap   = add_en & d_cur[DW-1];

   for (genvar j = 1; j < M; j++) begin : g_bit
      assign r_nxt[j-1] = r_cur[j] ^ (add_en & s_cur[j]);
      assign u_nxt[j-1] = u_cur[j] ^ (add_en & v_cur[j]) ^ (red_en & p_cur[j]);
   end
   assign r_nxt[M-1] = add_en & s_cur[M];
   assign u_nxt[M-1] = (add_en & v_cur[M]) ^ (red_en & p_cur[M]);

   always_comb begin
      if (swap) begin
         s_nxt = {1'b0, r_cur};
         v_nxt = {1'b0, u_cur};
         d_nxt = ~d_cur;         // -d - 1
      end else begin
         s_nxt = s_cur;
         v_nxt = v_cur;
         d_nxt = d_cur - DW'(1);
      end
   end

endmodule

// File: rtl/gf_seq_ctrl.sv
// Iteration counter, busy/done sequencing and operation latch.
module gf_seq_ctrl
   import gf_muldiv_pkg::*;
#(
   parameter int M = 8
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  gf_op_e op_in,
   output logic   busy,
   output logic   done,
   output logic   load,
   output logic   advance,
   output gf_op_e op_q
);

   localparam int CW = $clog2(2 * M);
   localparam logic [CW-1:0] MUL_LEFT = CW'(M - 1);
   localparam logic [CW-1:0] DIV_LEFT = CW'(2 * M - 2);

   logic [CW-1:0] left_q;

   assign load    = start & ~busy;
   assign advance = load | busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         left_q <= '0;
         op_q   <= OP_DIV;
      end else if (load) begin
         busy   <= 1'b1;
         done   <= 1'b0;
         op_q   <= op_in;
         left_q <= (op_in == OP_MUL) ? MUL_LEFT : DIV_LEFT;
      end else if (busy) begin
         if (left_q == CW'(1)) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            left_q <= '0;
         end else begin
            left_q <= left_q - CW'(1);
         end
      end else begin
         done <= 1'b0;
      end
   end

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_busy_after_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> busy);
   assert_op_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(op_q));
   assert_counter_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (left_q != '0 && left_q <= DIV_LEFT));

endmodule

// File: rtl/gf_muldiv.sv
module gf_muldiv
   import gf_muldiv_pkg::*;
#(
   parameter int M = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         mode,
   input  logic [M-1:0] a,
   input  logic [M-1:0] b,
   input  logic [M:0]   g,
   output logic         busy,
   output logic         done,
   output logic [M-1:0] result
);

   localparam int DW = $clog2(M + 1) + 1;

   if (M < 2) begin : g_bad_m
      $error("gf_muldiv: M must be at least 2");
   end
   if (DW < 3) begin : g_bad_dw
      $error("gf_muldiv: step counter too narrow");
   end

   gf_op_e op_q;
   logic   load, advance;

   logic [M-1:0]  r_q, u_q;
   logic [M:0]    s_q, v_q, p_q;
   logic [DW-1:0] d_q;

   logic [M-1:0]  r_i, u_i, r_c, u_c, r_n, u_n;
   logic [M:0]    s_i, v_i, p_i, s_c, v_c, p_c, s_n, v_n;
   logic [DW-1:0] d_i, d_c, d_n;
   logic          swap;

   gf_seq_ctrl #(.M(M)) i_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .op_in   (gf_op_e'(mode)),
      .busy    (busy),
      .done    (done),
      .load    (load),
      .advance (advance),
      .op_q    (op_q)
   );

   gf_operand_mux #(.M(M), .DW(DW)) i_mux (
      .op     (gf_op_e'(mode)),
      .a      (a),
      .b      (b),
      .g      (g),
      .r_init (r_i),
      .s_init (s_i),
      .u_init (u_i),
      .v_init (v_i),
      .p_init (p_i),
      .d_init (d_i)
   );

   // first iteration works from the pins, later ones from registers
   always_comb begin
      if (busy) begin
         r_c = r_q; s_c = s_q; u_c = u_q; v_c = v_q; p_c = p_q; d_c = d_q;
      end else begin
         r_c = r_i; s_c = s_i; u_c = u_i; v_c = v_i; p_c = p_i; d_c = d_i;
      end
   end

   gf_stein_step #(.M(M), .DW(DW)) i_step (
      .r_cur (r_c),
      .s_cur (s_c),
      .u_cur (u_c),
      .v_cur (v_c),
      .p_cur (p_c),
      .d_cur (d_c),
      .r_nxt (r_n),
      .s_nxt (s_n),
      .u_nxt (u_n),
      .v_nxt (v_n),
      .d_nxt (d_n),
      .swap  (swap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_q <= '0; s_q <= '0; u_q <= '0;
         v_q <= '0; p_q <= '0; d_q <= '0;
      end else if (advance) begin
         r_q <= r_n; s_q <= s_n; u_q <= u_n;
         v_q <= v_n; p_q <= p_c; d_q <= d_n;
      end
   end

   logic [M-1:0] u_rev;
   for (genvar i = 0; i < M; i++) begin : g_out_rev
      assign u_rev[i] = u_q[M-1-i];
   end

   assign result = (op_q == OP_MUL) ? u_rev : v_q[M-1:0];

   assert_mul_no_swap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_q == OP_MUL) |-> !swap);
   assert_mul_delta_nonneg_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_q == OP_MUL) |-> !d_q[DW-1]);
   assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(result));
   assert_v_top_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_q == OP_DIV) |-> !v_q[M]);

endmodule

// File: tb/test_gf_muldiv.sv
module test_gf_muldiv;

   localparam int CLK_PERIOD = 10;
   localparam int MB = 8;
   localparam int MS = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   int checks = 0;
   int failures = 0;

   // wide instance
   logic          st8 = 0, md8 = 0, busy8, done8;
   logic [MB-1:0] a8 = 0, b8 = 0, res8;
   logic [MB:0]   g8 = 0;

   gf_muldiv #(.M(MB)) i_gf_muldiv (
      .clk(clk), .rst_n(rst_n), .start(st8), .mode(md8), .a(a8), .b(b8),
      .g(g8), .busy(busy8), .done(done8), .result(res8)
   );

   // narrow instance
   logic          st4 = 0, md4 = 0, busy4, done4;
   logic [MS-1:0] a4 = 0, b4 = 0, res4;
   logic [MS:0]   g4 = 0;

   gf_muldiv #(.M(MS)) i_gf_muldiv_m4 (
      .clk(clk), .rst_n(rst_n), .start(st4), .mode(md4), .a(a4), .b(b4),
      .g(g4), .busy(busy4), .done(done4), .result(res4)
   );

   function automatic logic [8:0] ref_mul(int w, logic [8:0] x, logic [8:0] y, logic [8:0] gp);
      logic [9:0] acc = '0;
      for (int i = w - 1; i >= 0; i--) begin
         acc = acc << 1;
         if (acc[w]) acc = acc ^ {1'b0, gp};
         if (y[i]) acc = acc ^ {1'b0, x};
      end
      return acc[8:0];
   endfunction

   function automatic logic [8:0] ref_div(int w, logic [8:0] x, logic [8:0] y, logic [8:0] gp);
      for (int q = 0; q < (1 << w); q++)
         if (ref_mul(w, 9'(q), y, gp) == x) return 9'(q);
      return '0;
   endfunction

   task automatic check(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one operation on the wide instance; scramble inputs, optionally inject start
   task automatic run8(logic op, logic [MB-1:0] x, logic [MB-1:0] y, logic [MB:0] gp, bit inject);
      logic [MB-1:0] exp_res;
      int lat, n;
      exp_res = op ? MB'(ref_mul(MB, 9'(x), 9'(y), 9'(gp)))
                   : MB'(ref_div(MB, 9'(x), 9'(y), 9'(gp)));
      lat = op ? MB : 2 * MB - 1;
      @(negedge clk);
      md8 = op; a8 = x; b8 = y; g8 = gp; st8 = 1'b1;
      @(negedge clk);
      st8 = 1'b0;
      md8 = ~op; a8 = MB'($urandom); b8 = MB'($urandom); g8 = gp ^ 9'h0F0;   // R8 scramble
      check(busy8 == 1'b1, "R6 busy after start", longint'(busy8), 1);
      n = 1;
      while (!done8 && n < 100) begin
         if (inject && n == 2) st8 = 1'b1;      // R7 start while busy
         @(negedge clk);
         st8 = 1'b0;
         n++;
      end
      if (n >= 100) check(1'b0, "watchdog op", n, lat);
      check(n == lat, op ? "R4 mul latency" : "R5 div latency", n, lat);
      check(res8 == exp_res, op ? "R2 product" : (inject ? "R7 quotient" : "R3 quotient"),
            longint'(res8), longint'(exp_res));
      check(busy8 == 1'b0, "R6 busy low at done", longint'(busy8), 0);
      for (int k = 0; k < 3; k++) begin
         a8 = MB'($urandom); md8 = ~md8;
         @(negedge clk);
      end
      check(done8 == 1'b0, "R6 done pulse", longint'(done8), 0);
      check(res8 == exp_res, "R9 result held", longint'(res8), longint'(exp_res));
   endtask

   task automatic run4(logic op, logic [MS-1:0] x, logic [MS-1:0] y, logic [MS-1:0] exp_res);
      int n, lat;
      lat = op ? MS : 2 * MS - 1;
      @(negedge clk);
      md4 = op; a4 = x; b4 = y; g4 = 5'b10011; st4 = 1'b1;
      @(negedge clk);
      st4 = 1'b0; a4 = ~x; b4 = ~y;
      n = 1;
      while (!done4 && n < 100) begin
         @(negedge clk);
         n++;
      end
      check(n == lat, op ? "R4 mul latency M4" : "R5 div latency M4", n, lat);
      check(res4 == exp_res, "R10 worked case", longint'(res4), longint'(exp_res));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      check(1'b0, "watchdog global", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check(busy8 == 0 && done8 == 0 && res8 == 0, "R1 reset wide", longint'(res8), 0);
      check(busy4 == 0 && done4 == 0 && res4 == 0, "R1 reset narrow", longint'(res4), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy8 == 0 && res8 == 0, "R1 idle after reset", longint'(busy8), 0);

      // R10 worked case, computed reference also agrees
      run4(1'b1, 4'b1101, 4'b0111, 4'b0101);
      run4(1'b0, 4'b1101, 4'b0111, 4'b1000);
      check(ref_mul(4, 9'b1101, 9'b0111, 9'b10011) == 9'b0101, "R10 ref mul", 0, 5);

      // directed corner cases, R2 and R3
      run8(1'b1, 8'h00, 8'hA7, 9'h11B, 0);
      run8(1'b1, 8'h53, 8'h01, 9'h11B, 0);
      run8(1'b1, 8'hFF, 8'hFF, 9'h11B, 0);
      run8(1'b0, 8'h00, 8'h3C, 9'h11B, 0);
      run8(1'b0, 8'h9D, 8'h9D, 9'h11B, 0);
      run8(1'b0, 8'h01, 8'h53, 9'h11B, 0);
      run8(1'b0, 8'hFF, 8'h01, 9'h11D, 0);

      // random mix, two field polynomials, some injected starts (R7)
      for (int t = 0; t < 60; t++) begin
         logic [MB-1:0] x, y;
         logic op;
         x = MB'($urandom);
         y = MB'($urandom);
         op = 1'($urandom);
         if (!op && y == 0) y = 8'h01;
         run8(op, x, y, (t % 2 == 0) ? 9'h11B : 9'h11D, (t % 5 == 3));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule